// File: doc/BRIEF.md
# Locked Configuration Register Window

This block is the I/O slave behind a small group of disk-controller offsets. Normally every access at those offsets passes straight through to the command-register port. A short fixed access sequence opens a hidden configuration bank in place of the command registers. While it is open, no access is forwarded. A write at the gate offset closes the bank again.

The hidden bank holds two working timing sets, one per attached drive. Each set has a read-cycle timing byte, a write-cycle timing byte and an address-setup field. A device-select bit in the miscellaneous register chooses which set the timing registers address. A commit key written to the control register copies both working sets onto the committed timing outputs that the disk-bus cycle logic uses. A read-only strap register reports the bus clock speed from an input pin.

Top module: `cfg_window`

## Requirements
- R1: After reset the bank is closed (`bank_open`=0). Both working sets and both committed output sets hold the defaults: timing bytes 8'hFF and setup field 4'h3.
- R2: Three accesses in a row open the bank from the cycle after the third one. The first two are halfword reads (`io_half`=1) at offset 1. The third is a byte write (`io_half`=0) of 8'h03 at offset 2.
- R3: While the bank is closed, an access that does not match the next step of the R2 sequence leaves the bank closed and restarts the sequence from its first step. Examples are a wrong offset, a wrong size, a wrong value or an extra read.
- R4: While the bank is closed, `cmd_rd`/`cmd_wr` follow `io_rd`/`io_wr` in the same cycle, and `io_rdata` equals `cmd_rdata`.
- R5: While the bank is open, `cmd_rd` and `cmd_wr` stay 0, and reads return bank contents in `io_rdata[7:0]` with `io_rdata[15:8]`=0.
- R6: A byte write of 8'h83 at offset 2 while the bank is open closes it from the next cycle.
- R7: While the bank is open, writes at offset 0 (read timing) and offset 1 (write timing) update only the working set named by the device-select bit. Reads at those offsets return the selected set's values.
- R8: A write at offset 6 (misc) sets the device-select bit from data bit 0. In the same write, data bits 7:4 become the setup field of the device named by that bit 0. A read at offset 6 returns {setup of selected device, 3'b000, select}.
- R9: The committed outputs change only on a write of 8'h85 at offset 3 while the bank is open. That write copies working set 0 to the drive-0 outputs and working set 1 to the drive-1 outputs. Offset 3 reads back the last byte written there; other values are stored but do not commit.
- R10: While the bank is open, a read at offset 5 returns `strap_clk25` in bit 0 and zero elsewhere; writes at offset 5 change nothing.
- R11: While the bank is open, reads at offsets 2, 4 and 7 return 0. Writes there, other than the R6 close key at offset 2, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_off | input | 3 | Access offset |
| io_half | input | 1 | 1 = halfword access, 0 = byte access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 16 | Read data, valid in the strobe cycle |
| cmd_rdata | input | 16 | Read data from the command-register port |
| cmd_rd | output | 1 | Forwarded read strobe |
| cmd_wr | output | 1 | Forwarded write strobe |
| strap_clk25 | input | 1 | Bus clock strap, 0 = 33 MHz, 1 = 25 MHz |
| bank_open | output | 1 | Configuration bank is visible |
| drv0_rd_tim | output | 8 | Committed read timing, drive 0 |
| drv0_wr_tim | output | 8 | Committed write timing, drive 0 |
| drv0_setup | output | 4 | Committed address setup, drive 0 |
| drv1_rd_tim | output | 8 | Committed read timing, drive 1 |
| drv1_wr_tim | output | 8 | Committed write timing, drive 1 |
| drv1_setup | output | 4 | Committed address setup, drive 1 |

## Verification
Read data and the forwarded strobes are combinational, so they are due in the same cycle as the strobe. The monitor compares them at the falling edge inside that cycle. Register writes, bank opening and closing, and the commit all take effect at the rising edge that ends the write cycle. The driver checks `bank_open` and the committed outputs only after that edge, and it reads back working registers in a later access. Every read pushes its expected data and forwarding flag into the queue before the strobe is driven.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int OFF_W = 3;
  localparam int REG_W = 8;
  localparam int SET_W = 4;
  localparam int DEV_N = 2;
  localparam int BUS_W = 16;

  localparam logic [OFF_W-1:0] OFF_RDTIM = 3'd0;
  localparam logic [OFF_W-1:0] OFF_WRTIM = 3'd1;
  localparam logic [OFF_W-1:0] OFF_GATE  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STRAP = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MISC  = 3'd6;

  localparam logic [REG_W-1:0] KEY_OPEN   = 8'h03;
  localparam logic [REG_W-1:0] KEY_CLOSE  = 8'h83;
  localparam logic [REG_W-1:0] KEY_COMMIT = 8'h85;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_e;
endpackage

// File: rtl/cfg_window_seq.sv
module cfg_window_seq
  import cfg_window_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic             acc_half,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [REG_W-1:0] acc_byte,
  output logic             open_o
);
  seq_e seq_q, seq_d;
  logic open_q, open_d;
  logic any_acc, step_rd, step_key, close_hit;

  assign any_acc   = acc_rd | acc_wr;
  assign step_rd   = acc_rd & ~acc_wr & acc_half & (acc_off == OFF_WRTIM);
  assign step_key  = acc_wr & ~acc_rd & ~acc_half & (acc_off == OFF_GATE)
                     & (acc_byte == KEY_OPEN);
  assign close_hit = acc_wr & ~acc_half & (acc_off == OFF_GATE)
                     & (acc_byte == KEY_CLOSE);

  always_comb begin
    seq_d  = seq_q;
    open_d = open_q;
    if (open_q) begin
      seq_d = SEQ_IDLE;
      if (close_hit) open_d = 1'b0;
    end else if (any_acc) begin
      seq_d = SEQ_IDLE;
      unique case (seq_q)
        SEQ_IDLE: if (step_rd) seq_d = SEQ_ONE;
        SEQ_ONE:  if (step_rd) seq_d = SEQ_TWO;
        SEQ_TWO:  if (step_key) open_d = 1'b1;
        default:  seq_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_IDLE;
      open_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      open_q <= open_d;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/cfg_window_bank.sv
module cfg_window_bank
  import cfg_window_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_TIM   = 8'hFF,
  parameter logic [SET_W-1:0] DEF_SETUP = 4'h3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_rd,
  input  logic                        we_wr,
  input  logic                        we_misc,
  input  logic                        we_ctrl,
  input  logic [REG_W-1:0]            wbyte,
  output logic                        sel_o,
  output logic [REG_W-1:0]            cur_rd_o,
  output logic [REG_W-1:0]            cur_wr_o,
  output logic [SET_W-1:0]            cur_set_o,
  output logic [REG_W-1:0]            ctrl_o,
  output logic [DEV_N-1:0][REG_W-1:0] com_rd_o,
  output logic [DEV_N-1:0][REG_W-1:0] com_wr_o,
  output logic [DEV_N-1:0][SET_W-1:0] com_set_o
);
  logic                        sel_q, sel_en;
  logic [REG_W-1:0]            ctrl_q;
  logic                        commit;
  logic [DEV_N-1:0][REG_W-1:0] wrk_rd, wrk_wr;
  logic [DEV_N-1:0][SET_W-1:0] wrk_set;

  assign sel_en = we_misc;
  assign commit = we_ctrl & (wbyte == KEY_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (sel_en)  sel_q  <= wbyte[0];
      if (we_ctrl) ctrl_q <= wbyte;
    end
  end

  for (genvar d = 0; d < DEV_N; d++) begin : g_dev
    localparam logic DEV = 1'(d);
    logic             rd_en, wr_en, set_en;
    logic [REG_W-1:0] rd_q, wr_q, crd_q, cwr_q;
    logic [SET_W-1:0] set_q, cset_q;

    always_comb begin
      rd_en  = we_rd & (sel_q == DEV);
      wr_en  = we_wr & (sel_q == DEV);
      set_en = we_misc & (wbyte[0] == DEV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q   <= DEF_TIM;
        wr_q   <= DEF_TIM;
        set_q  <= DEF_SETUP;
        crd_q  <= DEF_TIM;
        cwr_q  <= DEF_TIM;
        cset_q <= DEF_SETUP;
      end else begin
        if (rd_en)  rd_q  <= wbyte;
        if (wr_en)  wr_q  <= wbyte;
        if (set_en) set_q <= wbyte[REG_W-1 -: SET_W];
        if (commit) begin
          crd_q  <= rd_q;
          cwr_q  <= wr_q;
          cset_q <= set_q;
        end
      end
    end

    assign wrk_rd[d]    = rd_q;
    assign wrk_wr[d]    = wr_q;
    assign wrk_set[d]   = set_q;
    assign com_rd_o[d]  = crd_q;
    assign com_wr_o[d]  = cwr_q;
    assign com_set_o[d] = cset_q;
  end

  assign sel_o     = sel_q;
  assign ctrl_o    = ctrl_q;
  assign cur_rd_o  = wrk_rd[sel_q];
  assign cur_wr_o  = wrk_wr[sel_q];
  assign cur_set_o = wrk_set[sel_q];
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_TIM   = 8'hFF,
  parameter logic [SET_W-1:0] DEF_SETUP = 4'h3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] io_off,
  input  logic             io_half,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [REG_W-1:0] io_wdata,
  output logic [BUS_W-1:0] io_rdata,
  input  logic [BUS_W-1:0] cmd_rdata,
  output logic             cmd_rd,
  output logic             cmd_wr,
  input  logic             strap_clk25,
  output logic             bank_open,
  output logic [REG_W-1:0] drv0_rd_tim,
  output logic [REG_W-1:0] drv0_wr_tim,
  output logic [SET_W-1:0] drv0_setup,
  output logic [REG_W-1:0] drv1_rd_tim,
  output logic [REG_W-1:0] drv1_wr_tim,
  output logic [SET_W-1:0] drv1_setup
);
  localparam int PAD_W = BUS_W - REG_W;
  localparam int GAP_W = REG_W - SET_W - 1;

  logic                        open;
  logic                        bwr;
  logic                        we_rd, we_wr, we_misc, we_ctrl;
  logic                        sel;
  logic [REG_W-1:0]            cur_rd, cur_wr, ctrl;
  logic [SET_W-1:0]            cur_set;
  logic [DEV_N-1:0][REG_W-1:0] com_rd, com_wr;
  logic [DEV_N-1:0][SET_W-1:0] com_set;
  logic [REG_W-1:0]            bank_byte;

  cfg_window_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_rd   (io_rd),
    .acc_wr   (io_wr),
    .acc_half (io_half),
    .acc_off  (io_off),
    .acc_byte (io_wdata),
    .open_o   (open)
  );

  assign bwr     = open & io_wr;
  assign we_rd   = bwr & (io_off == OFF_RDTIM);
  assign we_wr   = bwr & (io_off == OFF_WRTIM);
  assign we_misc = bwr & (io_off == OFF_MISC);
  assign we_ctrl = bwr & (io_off == OFF_CTRL);

  cfg_window_bank #(
    .DEF_TIM   (DEF_TIM),
    .DEF_SETUP (DEF_SETUP)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_rd     (we_rd),
    .we_wr     (we_wr),
    .we_misc   (we_misc),
    .we_ctrl   (we_ctrl),
    .wbyte     (io_wdata),
    .sel_o     (sel),
    .cur_rd_o  (cur_rd),
    .cur_wr_o  (cur_wr),
    .cur_set_o (cur_set),
    .ctrl_o    (ctrl),
    .com_rd_o  (com_rd),
    .com_wr_o  (com_wr),
    .com_set_o (com_set)
  );

  always_comb begin
    unique case (io_off)
      OFF_RDTIM: bank_byte = cur_rd;
      OFF_WRTIM: bank_byte = cur_wr;
      OFF_CTRL:  bank_byte = ctrl;
      OFF_STRAP: bank_byte = {{(REG_W-1){1'b0}}, strap_clk25};
      OFF_MISC:  bank_byte = {cur_set, {GAP_W{1'b0}}, sel};
      default:   bank_byte = '0;
    endcase
  end

  always_comb begin
    if (open) io_rdata = {{PAD_W{1'b0}}, bank_byte};
    else      io_rdata = cmd_rdata;
  end

  assign cmd_rd      = io_rd & ~open;
  assign cmd_wr      = io_wr & ~open;
  assign bank_open   = open;
  assign drv0_rd_tim = com_rd[0];
  assign drv0_wr_tim = com_wr[0];
  assign drv0_setup  = com_set[0];
  assign drv1_rd_tim = com_rd[1];
  assign drv1_wr_tim = com_wr[1];
  assign drv1_setup  = com_set[1];
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk
  import cfg_window_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OFF_W-1:0] io_off,
  input logic             io_half,
  input logic             io_rd,
  input logic             io_wr,
  input logic [REG_W-1:0] io_wdata,
  input logic [BUS_W-1:0] io_rdata,
  input logic [BUS_W-1:0] cmd_rdata,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             strap_clk25,
  input logic             bank_open,
  input logic [REG_W-1:0] drv0_rd_tim,
  input logic [REG_W-1:0] drv0_wr_tim,
  input logic [SET_W-1:0] drv0_setup,
  input logic [REG_W-1:0] drv1_rd_tim,
  input logic [REG_W-1:0] drv1_wr_tim,
  input logic [SET_W-1:0] drv1_setup
);
  logic [2*REG_W*2+2*SET_W-1:0] com_all;
  assign com_all = {drv0_rd_tim, drv0_wr_tim, drv0_setup,
                    drv1_rd_tim, drv1_wr_tim, drv1_setup};

  assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_open) |-> $past(io_wr && !io_half && io_off == OFF_GATE
                               && io_wdata == KEY_OPEN));

  assert_locked_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |-> io_rdata == cmd_rdata);

  assert_open_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_open |-> !cmd_rd && !cmd_wr && io_rdata[BUS_W-1:REG_W] == '0);

  assert_close_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bank_open) |-> $past(io_wr && io_off == OFF_GATE
                               && io_wdata == KEY_CLOSE));

  assert_commit_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(com_all) |-> $past(bank_open && io_wr && io_off == OFF_CTRL
                                && io_wdata == KEY_COMMIT));

  assert_strap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_open && io_rd && io_off == OFF_STRAP) |-> io_rdata[0] == strap_clk25);
endmodule

bind cfg_window cfg_window_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_off      (io_off),
  .io_half     (io_half),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .cmd_rdata   (cmd_rdata),
  .cmd_rd      (cmd_rd),
  .cmd_wr      (cmd_wr),
  .strap_clk25 (strap_clk25),
  .bank_open   (bank_open),
  .drv0_rd_tim (drv0_rd_tim),
  .drv0_wr_tim (drv0_wr_tim),
  .drv0_setup  (drv0_setup),
  .drv1_rd_tim (drv1_rd_tim),
  .drv1_wr_tim (drv1_wr_tim),
  .drv1_setup  (drv1_setup)
);

// File: tb/cfg_window_tb.sv
module cfg_window_tb;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic [2:0]  io_off;
  logic        io_half, io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic [15:0] io_rdata, cmd_rdata;
  logic        cmd_rd, cmd_wr, strap_clk25, bank_open;
  logic [7:0]  drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim;
  logic [3:0]  drv0_setup, drv1_setup;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] d;
    logic        f;
    string       tag;
  } item_t;
  item_t sb[$];

  assign cmd_rdata = 16'hA500 | {13'b0, io_off};

  cfg_window u_dut (
    .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_half(io_half),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cmd_rdata(cmd_rdata), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .strap_clk25(strap_clk25), .bank_open(bank_open),
    .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim), .drv0_setup(drv0_setup),
    .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim), .drv1_setup(drv1_setup)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every read strobe pops one expected item, compared mid-cycle.
  always @(negedge clk) begin
    if (io_rd && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk({it.tag, " rdata"}, {16'h0, io_rdata}, {16'h0, it.d});
      chk({it.tag, " cmd_rd"}, {31'h0, cmd_rd}, {31'h0, it.f});
    end
  end

  task automatic rd(logic [2:0] off, logic half, logic [15:0] d, logic f, string tag);
    item_t it;
    it.d = d; it.f = f; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    io_off = off; io_half = half; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic wr(logic [2:0] off, logic half, logic [7:0] d, logic f, string tag);
    @(posedge clk); #1;
    io_off = off; io_half = half; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    chk({tag, " cmd_wr"}, {31'h0, cmd_wr}, {31'h0, f});
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic chk_com(string tag, logic [7:0] r0, logic [7:0] w0, logic [3:0] s0,
                         logic [7:0] r1, logic [7:0] w1, logic [3:0] s1);
    @(negedge clk);
    chk({tag, " drv0"}, {12'h0, drv0_rd_tim, drv0_wr_tim, drv0_setup}, {12'h0, r0, w0, s0});
    chk({tag, " drv1"}, {12'h0, drv1_rd_tim, drv1_wr_tim, drv1_setup}, {12'h0, r1, w1, s1});
  endtask

  task automatic chk_open(string tag, logic e);
    @(negedge clk);
    chk({tag, " bank_open"}, {31'h0, bank_open}, {31'h0, e});
  endtask

  task automatic unlock(logic half_wr, logic [7:0] key);
    rd(3'd1, 1'b1, 16'hA501, 1'b1, "R4 seq rd");
    rd(3'd1, 1'b1, 16'hA501, 1'b1, "R4 seq rd");
    wr(3'd2, half_wr, key, 1'b1, "R4 seq wr");
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; io_off = 0; io_half = 0; io_rd = 0; io_wr = 0; io_wdata = 0;
    strap_clk25 = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_open("R1", 1'b0);
    chk_com("R1", 8'hFF, 8'hFF, 4'h3, 8'hFF, 8'hFF, 4'h3);

    // R4 pass-through while locked
    rd(3'd0, 1'b0, 16'hA500, 1'b1, "R4");
    wr(3'd0, 1'b0, 8'h12, 1'b1, "R4");

    // R3 broken sequences
    unlock(1'b0, 8'h04);
    chk_open("R3 wrong key", 1'b0);
    wr(3'd2, 1'b0, 8'h03, 1'b1, "R3");
    chk_open("R3 key alone", 1'b0);
    rd(3'd1, 1'b1, 16'hA501, 1'b1, "R3");
    rd(3'd0, 1'b1, 16'hA500, 1'b1, "R3");
    wr(3'd2, 1'b0, 8'h03, 1'b1, "R3");
    chk_open("R3 wrong offset", 1'b0);
    unlock(1'b1, 8'h03);
    chk_open("R3 wrong size", 1'b0);
    rd(3'd1, 1'b1, 16'hA501, 1'b1, "R3");
    unlock(1'b0, 8'h03);
    chk_open("R3 extra read", 1'b0);

    // R2 proper unlock
    unlock(1'b0, 8'h03);
    chk_open("R2", 1'b1);

    // R10 strap, R5 no forwarding
    rd(3'd5, 1'b0, 16'h0001, 1'b0, "R10 R5");
    strap_clk25 = 0;
    rd(3'd5, 1'b0, 16'h0000, 1'b0, "R10");
    wr(3'd5, 1'b0, 8'hFF, 1'b0, "R10 R5");
    rd(3'd5, 1'b0, 16'h0000, 1'b0, "R10 write ignored");

    // R7 per-device working sets
    wr(3'd6, 1'b0, 8'h00, 1'b0, "R7");
    wr(3'd0, 1'b0, 8'h11, 1'b0, "R7");
    wr(3'd1, 1'b0, 8'h22, 1'b0, "R7");
    wr(3'd6, 1'b0, 8'h01, 1'b0, "R7");
    rd(3'd0, 1'b0, 16'h00FF, 1'b0, "R7 dev1 default");
    wr(3'd0, 1'b0, 8'h33, 1'b0, "R7");
    wr(3'd1, 1'b0, 8'h44, 1'b0, "R7");
    rd(3'd0, 1'b0, 16'h0033, 1'b0, "R7 dev1 rd");
    rd(3'd1, 1'b0, 16'h0044, 1'b0, "R7 dev1 wr");
    wr(3'd6, 1'b0, 8'h00, 1'b0, "R7");
    rd(3'd0, 1'b0, 16'h0011, 1'b0, "R7 dev0 rd");
    rd(3'd1, 1'b0, 16'h0022, 1'b0, "R7 dev0 wr");

    // R8 misc select and setup field
    wr(3'd6, 1'b0, 8'h21, 1'b0, "R8");
    rd(3'd6, 1'b0, 16'h0021, 1'b0, "R8 dev1");
    wr(3'd6, 1'b0, 8'h30, 1'b0, "R8");
    rd(3'd6, 1'b0, 16'h0030, 1'b0, "R8 dev0");

    // R11 unused offsets
    rd(3'd4, 1'b0, 16'h0000, 1'b0, "R11");
    rd(3'd7, 1'b0, 16'h0000, 1'b0, "R11");
    wr(3'd2, 1'b0, 8'h10, 1'b0, "R11");
    chk_open("R11 gate other value", 1'b1);
    rd(3'd2, 1'b0, 16'h0000, 1'b0, "R11");
    wr(3'd4, 1'b0, 8'h5A, 1'b0, "R11");
    rd(3'd0, 1'b0, 16'h0011, 1'b0, "R11 no side effect");

    // R9 commit
    chk_com("R9 before", 8'hFF, 8'hFF, 4'h3, 8'hFF, 8'hFF, 4'h3);
    wr(3'd3, 1'b0, 8'h84, 1'b0, "R9");
    chk_com("R9 wrong key", 8'hFF, 8'hFF, 4'h3, 8'hFF, 8'hFF, 4'h3);
    rd(3'd3, 1'b0, 16'h0084, 1'b0, "R9 ctrl readback");
    wr(3'd3, 1'b0, 8'h85, 1'b0, "R9");
    chk_com("R9 commit", 8'h11, 8'h22, 4'h3, 8'h33, 8'h44, 4'h2);
    rd(3'd3, 1'b0, 16'h0085, 1'b0, "R9 ctrl readback");

    // R6 close
    wr(3'd2, 1'b0, 8'h83, 1'b0, "R6");
    chk_open("R6", 1'b0);
    rd(3'd0, 1'b0, 16'hA500, 1'b1, "R6 R4 pass again");
    chk_com("R6 outputs kept", 8'h11, 8'h22, 4'h3, 8'h33, 8'h44, 4'h2);

    repeat (2) @(posedge clk);
    chk("scoreboard drained", sb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule